// File: doc/BRIEF.md
# Manchester Word Transmitter with Loopback Check

This block turns 16-bit words from a protocol controller into a self-clocking serial stream at 1 Mbit/s. Each word is framed as 20 bit times. Three bit times of sync come first, and their shape marks the word as either a command/status word or a data word. The 16 payload bits follow, most significant first, and one odd-parity bit closes the frame. Every bit is sent as two half-bit levels on a complementary output pair. A single encoder produces the stream, and two enables choose whether it reaches redundant bus A, bus B, both or neither.

The controller hands over words through a one-deep holding register, using a load strobe and a busy flag. A word loaded while another is on the line goes out directly after it, with no idle gap. A fail-safe timer watches how long the line has been driven without a break. If that time exceeds a limit, the timer stops the transmission and locks the transmitter off until reset. A loopback checker holds a copy of each finished word. It expects the same word and type to come back from the receive path within a short window, and it raises a sticky failure flag on a mismatch or when nothing comes back.

Top module: `mtx_encoder`

## Requirements
- R1: After reset, tx_busy, tx_active, tx_timeout, loop_fail and all four bus outputs are 0.
- R2: The first 3 bit times of a word are sync. For a command word (tx_is_cmd=1) the positive line is high for 1.5 bit times and then low for 1.5 bit times. For a data word it is low and then high.
- R3: The payload follows the sync, bit 15 first. A 1 is sent with the positive line high in the first half of the bit time and low in the second half. A 0 is sent low then high.
- R4: The 20th bit time carries odd parity over the 16 payload bits, encoded as in R3.
- R5: bus_a_p/bus_a_n carry the stream only while bus_en_a=1, and bus_b_p/bus_b_n only while bus_en_b=1. While a line is driven, its n output is the complement of its p output. When the transmitter is idle, or a bus is disabled, both lines of that bus are 0.
- R6: tx_busy is 1 while the holding register is occupied. A tx_load strobe applied while tx_busy=1 is discarded.
- R7: A word loaded before the current word's parity bit ends starts on the very next half-bit. tx_active stays 1 across the word boundary.
- R8: If tx_active stays high without a break, it is high for exactly TMO_US microseconds of clock cycles, then drops, and tx_timeout rises.
- R9: Once tx_timeout is 1, it stays 1 and no later load produces bus activity until reset.
- R10: Any idle cycle between words restarts the timeout count, so separated words never trip the timer, however many are sent.
- R11: An echo (rx_valid with equal rx_data and rx_is_cmd) that arrives within LOOP_US microseconds of clock cycles after a word ends leaves loop_fail at 0.
- R12: An echo whose data or type differs from the finished word sets loop_fail.
- R13: If no echo arrives within the window, loop_fail is set. An echo that arrives when no word is awaiting comparison has no effect.
- R14: loop_fail stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_load | input | 1 | Strobe to take tx_data/tx_is_cmd into the holding register |
| tx_data | input | 16 | Word to transmit |
| tx_is_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| tx_busy | output | 1 | Holding register occupied |
| tx_active | output | 1 | Line is being driven |
| bus_en_a | input | 1 | Enable for bus A |
| bus_en_b | input | 1 | Enable for bus B |
| bus_a_p | output | 1 | Bus A positive line |
| bus_a_n | output | 1 | Bus A negative line |
| bus_b_p | output | 1 | Bus B positive line |
| bus_b_n | output | 1 | Bus B negative line |
| tx_timeout | output | 1 | Fail-safe timer tripped (latched) |
| rx_valid | input | 1 | Decoded word from receive path is valid |
| rx_data | input | 16 | Decoded word from receive path |
| rx_is_cmd | input | 1 | Decoded sync type |
| loop_fail | output | 1 | Loopback mismatch or missing echo (sticky) |

## Verification
The bench decodes the line at mid half-bit and checks it against walking-one, all-zero, all-one and alternating words, each sent as both types. A swapped sync, reversed bit order or even parity would show up as a wrong half-symbol at a known position. It drives all four enable combinations, so a swapped or ignored enable would leave the wrong bus driven. It checks the back-to-back join and the exact count of cycles before the timeout. An off-by-one in the timer, a gap between stacked words, or a counter that is not cleared between separated words would change that count or the flag. The loopback window is probed at its last accepted cycle and one cycle beyond, and with single-bit data flips, a type flip and a stray echo. A window of the wrong length, a comparison that misses some bits, or a flag that is not sticky would each give a wrong loop_fail.

// File: rtl/mtx_pkg.sv
// Package: shared word type and the half-bit symbol builder for the
// Manchester transmitter. Assumes a 20-bit-time frame of 40 half-bits.
package mtx_pkg;

    localparam int DATA_W   = 16;
    localparam int SYNC_HB  = 6;                       // sync half-bits
    localparam int SYMS     = SYNC_HB + 2 * (DATA_W + 1);

    typedef struct packed {
        logic              is_cmd;
        logic [DATA_W-1:0] data;
    } mtx_word_t;

    // Build the half-bit pattern of a word, first symbol at the MSB.
    function automatic logic [SYMS-1:0] build_syms(input mtx_word_t w);
        logic [SYMS-1:0] v;
        logic            par;
        v   = '0;
        par = ~(^w.data);
        v[SYMS-1 -: SYNC_HB] = w.is_cmd ? 6'b111000 : 6'b000111;
        for (int i = 0; i < DATA_W; i++) begin
            v[2*i + 3] = w.data[i];
            v[2*i + 2] = ~w.data[i];
        end
        v[1] = par;
        v[0] = ~par;
        return v;
    endfunction

endpackage

// File: rtl/mtx_serializer.sv
// Serializer: shifts a 40-symbol Manchester frame out, one symbol per
// HALF_CLKS clocks. Assumes start is only raised when ready is high; a
// start on the last clock of a frame chains the next frame with no gap.
module mtx_serializer
    import mtx_pkg::*;
#(
    parameter int HALF_CLKS = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      kill,
    input  mtx_word_t word_in,
    output logic      active,
    output logic      sym,
    output logic      ready,
    output logic      done,
    output mtx_word_t cur
);
    localparam int DIV_W = $clog2(HALF_CLKS + 1);
    localparam int CNT_W = $clog2(SYMS + 1);

    logic [SYMS-1:0]  sr_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] hcnt_q;
    logic             half_end;
    logic             last;

    // Frame boundary decode.
    always_comb begin
        half_end = (div_q == DIV_W'(HALF_CLKS - 1));
        last     = active && half_end && (hcnt_q == CNT_W'(SYMS - 1));
        done     = last;
        ready    = !active || last;
        sym      = sr_q[SYMS-1];
    end

    // Load, shift and terminate the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sr_q   <= '0;
            div_q  <= '0;
            hcnt_q <= '0;
            cur    <= '0;
        end else if (kill) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            sr_q   <= build_syms(word_in);
            div_q  <= '0;
            hcnt_q <= '0;
            cur    <= word_in;
        end else if (active) begin
            if (half_end) begin
                div_q <= '0;
                if (last) begin
                    active <= 1'b0;
                end else begin
                    sr_q   <= sr_q << 1;
                    hcnt_q <= hcnt_q + CNT_W'(1);
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/mtx_tx_watchdog.sv
// Fail-safe timer: counts clocks of unbroken line activity and latches
// tripped after LIMIT of them. Assumes any idle clock ends a burst.
module mtx_tx_watchdog #(
    parameter int LIMIT = 9600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tripped
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count the burst length and latch the trip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tripped <= 1'b0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (!tripped) begin
            if (cnt_q == CW'(LIMIT - 1)) tripped <= 1'b1;
            else                         cnt_q   <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/mtx_loopback.sv
// Loopback checker: arms on each finished frame, then expects a matching
// decoded word within WIN clocks. Assumes WIN is shorter than a frame;
// a new frame ending while still armed counts as a missing echo.
module mtx_loopback
    import mtx_pkg::*;
#(
    parameter int WIN = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  mtx_word_t         sent,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_cmd,
    output logic              fail
);
    localparam int WW = $clog2(WIN + 1);

    mtx_word_t     exp_q;
    logic          armed_q;
    logic [WW-1:0] cnt_q;
    logic          expire;
    logic          mism;

    // Window end and comparison result.
    always_comb begin
        expire = (cnt_q == WW'(WIN - 1));
        mism   = (rx_data != exp_q.data) || (rx_is_cmd != exp_q.is_cmd);
    end

    // Arm, compare, time out and latch the failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q   <= '0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            fail    <= 1'b0;
        end else begin
            if (armed_q) begin
                if (rx_valid) begin
                    if (mism) fail <= 1'b1;
                    armed_q <= 1'b0;
                end else if (expire || done) begin
                    fail    <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + WW'(1);
                end
            end
            if (done) begin
                armed_q <= 1'b1;
                exp_q   <= sent;
                cnt_q   <= '0;
            end
        end
    end

endmodule

// File: rtl/mtx_encoder.sv
// Top: one Manchester transmitter gated onto two redundant buses, with a
// one-deep holding register, fail-safe timer and loopback check.
// Assumes CLK_HZ is a multiple of 2 MHz (whole clocks per half-bit).
module mtx_encoder
    import mtx_pkg::*;
#(
    parameter int CLK_HZ  = 12_000_000,
    parameter int TMO_US  = 800,
    parameter int LOOP_US = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_is_cmd,
    output logic              tx_busy,
    output logic              tx_active,
    input  logic              bus_en_a,
    input  logic              bus_en_b,
    output logic              bus_a_p,
    output logic              bus_a_n,
    output logic              bus_b_p,
    output logic              bus_b_n,
    output logic              tx_timeout,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_cmd,
    output logic              loop_fail
);
    localparam int CLK_PER_US = CLK_HZ / 1_000_000;
    localparam int HALF_CLKS  = CLK_HZ / 2_000_000;
    localparam int TMO_CLKS   = CLK_PER_US * TMO_US;
    localparam int LOOP_CLKS  = CLK_PER_US * LOOP_US;
    localparam int NBUS       = 2;

    mtx_word_t        pend_q;
    logic             pend_v_q;
    logic             ser_active, ser_sym, ser_ready, ser_done;
    logic             start, tripped, drive;
    mtx_word_t        ser_cur;
    logic [NBUS-1:0]  en_vec, p_vec, n_vec;

    // Start a frame when a word waits, the line is free and not locked off.
    always_comb begin
        start     = pend_v_q && ser_ready && !tripped;
        tx_busy   = pend_v_q;
        drive     = ser_active && !tripped;
        tx_active = drive;
    end

    // Holding register between the controller and the serializer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q <= 1'b0;
            pend_q   <= '0;
        end else if (start) begin
            pend_v_q <= 1'b0;
        end else if (tx_load && !pend_v_q) begin
            pend_v_q <= 1'b1;
            pend_q   <= '{is_cmd: tx_is_cmd, data: tx_data};
        end
    end

    mtx_serializer #(.HALF_CLKS(HALF_CLKS)) ser_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .kill   (tripped),
        .word_in(pend_q),
        .active (ser_active),
        .sym    (ser_sym),
        .ready  (ser_ready),
        .done   (ser_done),
        .cur    (ser_cur)
    );

    mtx_tx_watchdog #(.LIMIT(TMO_CLKS)) wdg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (ser_active),
        .tripped(tripped)
    );

    mtx_loopback #(.WIN(LOOP_CLKS)) lpb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (ser_done),
        .sent     (ser_cur),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_is_cmd(rx_is_cmd),
        .fail     (loop_fail)
    );

    assign en_vec = {bus_en_b, bus_en_a};

    // Per-bus output gating of the single encoded stream.
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        assign p_vec[b] = en_vec[b] & drive &  ser_sym;
        assign n_vec[b] = en_vec[b] & drive & ~ser_sym;
    end

    assign bus_a_p    = p_vec[0];
    assign bus_a_n    = n_vec[0];
    assign bus_b_p    = p_vec[1];
    assign bus_b_n    = n_vec[1];
    assign tx_timeout = tripped;

endmodule

// File: rtl/mtx_encoder_chk.sv
// Checker: temporal properties of the transmitter ports, bound to the top.
module mtx_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic bus_en_a,
    input logic bus_en_b,
    input logic bus_a_p,
    input logic bus_a_n,
    input logic bus_b_p,
    input logic bus_b_n,
    input logic tx_timeout,
    input logic loop_fail
);
    // R5
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_a_p && bus_a_n) && !(bus_b_p && bus_b_n));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !(bus_a_p || bus_a_n || bus_b_p || bus_b_n));

    // R5
    driven_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> ((bus_a_p != bus_a_n) == bus_en_a) && ((bus_b_p != bus_b_n) == bus_en_b));

    // R9
    tmo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_timeout |=> tx_timeout);

    // R9
    tmo_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_timeout |-> !tx_active);

    // R14
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_fail |=> loop_fail);

endmodule

bind mtx_encoder mtx_encoder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .bus_en_a  (bus_en_a),
    .bus_en_b  (bus_en_b),
    .bus_a_p   (bus_a_p),
    .bus_a_n   (bus_a_n),
    .bus_b_p   (bus_b_p),
    .bus_b_n   (bus_b_n),
    .tx_timeout(tx_timeout),
    .loop_fail (loop_fail)
);

// File: tb/mtx_encoder_tb_top.sv
// Bench: 4 MHz clock model (2 clocks per half-bit, 80 per word), 50 us
// timeout (200 clocks) and 4 us loopback window (16 clocks).
module mtx_encoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int TMO_US     = 50;
    localparam int LOOP_US    = 4;
    localparam int HALF       = CLK_HZ / 2_000_000;
    localparam int TMO_CLKS   = TMO_US * (CLK_HZ / 1_000_000);
    localparam int WIN        = LOOP_US * (CLK_HZ / 1_000_000);

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_load = 0, tx_is_cmd = 0, bus_en_a = 1, bus_en_b = 1;
    logic rx_valid = 0, rx_is_cmd = 0;
    logic [15:0] tx_data = '0, rx_data = '0;
    logic tx_busy, tx_active, bus_a_p, bus_a_n, bus_b_p, bus_b_n, tx_timeout, loop_fail;

    int tests = 0, fails = 0;
    int act_cnt = 0, bus_cnt = 0;
    bit stream = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtx_encoder #(.CLK_HZ(CLK_HZ), .TMO_US(TMO_US), .LOOP_US(LOOP_US)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_data(tx_data),
        .tx_is_cmd(tx_is_cmd), .tx_busy(tx_busy), .tx_active(tx_active),
        .bus_en_a(bus_en_a), .bus_en_b(bus_en_b), .bus_a_p(bus_a_p),
        .bus_a_n(bus_a_n), .bus_b_p(bus_b_p), .bus_b_n(bus_b_n),
        .tx_timeout(tx_timeout), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_is_cmd(rx_is_cmd), .loop_fail(loop_fail));

    // Activity monitor and continuous loader for the timeout test.
    always @(negedge clk) begin
        if (tx_active) act_cnt++;
        if (bus_a_p | bus_a_n | bus_b_p | bus_b_n) bus_cnt++;
        if (stream) tx_load <= !tx_busy;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        stream = 0;
        rst_n = 0; tx_load = 0; rx_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic load_word(input logic [15:0] w, input logic c);
        int g = 0;
        while (tx_busy && g < 1000) begin @(negedge clk); g++; end
        tx_data = w; tx_is_cmd = c; tx_load = 1;
        @(negedge clk);
        tx_load = 0;
    endtask

    // Expected half-bit h (0 first) of a word, computed per bit time.
    function automatic logic exp_half(input logic [15:0] w, input logic c, input int h);
        int ones = 0;
        logic v;
        for (int i = 0; i < 16; i++) ones += w[i];
        if (h < 6)       v = c ? (h < 3) : (h >= 3);
        else if (h < 38) v = w[15 - (h - 6) / 2] ^ (h % 2 == 1);
        else             v = ((ones % 2) == 0) ^ (h % 2 == 1);
        return v;
    endfunction

    // Capture nh half-bits from both buses starting at the first active cycle.
    task automatic capture(input int nh, output logic [79:0] pa, output logic [79:0] na,
                           output logic [79:0] pb, output logic [79:0] nb, output int gaps);
        int g = 0;
        pa = '0; na = '0; pb = '0; nb = '0; gaps = 0;
        while (!tx_active && g < 1000) begin @(negedge clk); g++; end
        for (int k = 0; k < nh; k++) begin
            if (!tx_active) gaps++;
            pa[k] = bus_a_p; na[k] = bus_a_n; pb[k] = bus_b_p; nb[k] = bus_b_n;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        while (tx_active && g < 1000) begin @(negedge clk); g++; end
    endtask

    task automatic check_word(input logic [15:0] w, input logic c);
        logic [79:0] pa, na, pb, nb;
        logic [79:0] e;
        int gaps;
        e = '0;
        for (int h = 0; h < 40; h++) e[h] = exp_half(w, c, h);
        load_word(w, c);
        capture(40, pa, na, pb, nb, gaps);
        chk(pa[5:0] == e[5:0], "R2 sync", pa[5:0], e[5:0]);
        chk(pa[37:6] == e[37:6], "R3 payload", pa[37:6], e[37:6]);
        chk(pa[39:38] == e[39:38], "R4 parity", pa[39:38], e[39:38]);
        chk(na[39:0] == ~e[39:0] && pb[39:0] == e[39:0] && nb[39:0] == ~e[39:0],
            "R5 pair", {pb[39:0], na[39:0]}, {e[39:0], ~e[39:0]});
        wait_idle();
    endtask

    task automatic loop_case(input logic [15:0] w, input logic c, input bit echo,
                             input int dly, input logic [15:0] rw, input logic rc,
                             input bit exp_fail, input string req);
        do_reset();
        load_word(w, c);
        @(negedge clk);
        while (!tx_active) @(negedge clk);
        wait_idle();
        repeat (dly) @(negedge clk);
        if (echo) begin
            rx_valid = 1; rx_data = rw; rx_is_cmd = rc;
            @(negedge clk);
            rx_valid = 0;
        end
        repeat (WIN + 3) @(negedge clk);
        chk(loop_fail == exp_fail, req, loop_fail, exp_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [79:0] pa, na, pb, nb, e;
        int gaps;

        do_reset();
        // R1 reset state
        chk({tx_busy, tx_active, tx_timeout, loop_fail, bus_a_p, bus_a_n, bus_b_p, bus_b_n} == 8'h0,
            "R1 reset", {tx_busy, tx_active, tx_timeout, loop_fail}, 0);

        // R2 R3 R4 R5: sweep of patterns, both sync types
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 16; i++) check_word(16'h1 << i, t[0]);
            check_word(16'h0000, t[0]);
            check_word(16'hFFFF, t[0]);
            check_word(16'hA5A5, t[0]);
            check_word(16'h5A5A, t[0]);
        end

        // R5 all enable combinations
        for (int m = 0; m < 4; m++) begin
            bus_en_a = m[0]; bus_en_b = m[1];
            load_word(16'hC3A1, 1'b0);
            capture(40, pa, na, pb, nb, gaps);
            e = '0;
            for (int h = 0; h < 40; h++) e[h] = exp_half(16'hC3A1, 1'b0, h);
            chk(pa[39:0] == (m[0] ? e[39:0] : 40'h0) && na[39:0] == (m[0] ? ~e[39:0] : 40'h0),
                "R5 bus A gating", pa[39:0], m[0] ? e[39:0] : 40'h0);
            chk(pb[39:0] == (m[1] ? e[39:0] : 40'h0) && nb[39:0] == (m[1] ? ~e[39:0] : 40'h0),
                "R5 bus B gating", pb[39:0], m[1] ? e[39:0] : 40'h0);
            wait_idle();
        end
        bus_en_a = 1; bus_en_b = 1;

        // R7 back-to-back words with no gap
        do_reset();
        load_word(16'h1234, 1'b1);
        load_word(16'hBEEF, 1'b0);
        capture(80, pa, na, pb, nb, gaps);
        e = '0;
        for (int h = 0; h < 40; h++) begin
            e[h] = exp_half(16'h1234, 1'b1, h);
            e[h+40] = exp_half(16'hBEEF, 1'b0, h);
        end
        chk(pa == e, "R7 chained stream", pa, e);
        chk(gaps == 0, "R7 no gap", gaps, 0);

        // R6 load while busy is discarded: two words go out, third is dropped
        do_reset();
        act_cnt = 0;
        load_word(16'h0F0F, 1'b0);
        load_word(16'hF0F0, 1'b0);
        chk(tx_busy == 1'b1, "R6 busy while holding full", tx_busy, 1);
        tx_data = 16'h7777; tx_load = 1;
        @(negedge clk);
        tx_load = 0;
        repeat (300) @(negedge clk);
        chk(act_cnt == 160, "R6 dropped load", act_cnt, 160);
        chk(tx_timeout == 1'b0, "R7 160 cycles no trip", tx_timeout, 0);

        // R10 separated words never trip
        do_reset();
        act_cnt = 0;
        for (int i = 0; i < 4; i++) begin
            load_word(16'h00FF, 1'b1);
            @(negedge clk);
            while (!tx_active) @(negedge clk);
            wait_idle();
            repeat (2) @(negedge clk);
        end
        chk(act_cnt == 320 && tx_timeout == 1'b0, "R10 gaps restart timer", {act_cnt, tx_timeout}, 320 * 2);

        // R8 R9 continuous stream trips after exactly TMO_CLKS active cycles
        do_reset();
        act_cnt = 0;
        stream = 1;
        repeat (400) @(negedge clk);
        chk(act_cnt == TMO_CLKS, "R8 active length", act_cnt, TMO_CLKS);
        chk(tx_timeout == 1'b1, "R8 timeout flag", tx_timeout, 1);
        bus_cnt = 0;
        repeat (300) @(negedge clk);
        stream = 0;
        tx_load = 0;
        chk(act_cnt == TMO_CLKS && bus_cnt == 0, "R9 locked off", bus_cnt, 0);
        chk(tx_timeout == 1'b1, "R9 flag held", tx_timeout, 1);

        // R11 R12 R13 R14 loopback
        loop_case(16'h2468, 1'b1, 1, 0, 16'h2468, 1'b1, 0, "R11 immediate echo");
        loop_case(16'h2468, 1'b0, 1, WIN - 1, 16'h2468, 1'b0, 0, "R11 echo at window end");
        loop_case(16'h2468, 1'b0, 1, WIN, 16'h2468, 1'b0, 1, "R13 echo after window");
        loop_case(16'h2468, 1'b0, 0, 0, 16'h0, 1'b0, 1, "R13 no echo");
        loop_case(16'h2468, 1'b1, 1, 3, 16'h2468, 1'b0, 1, "R12 type mismatch");
        for (int i = 0; i < 16; i++)
            loop_case(16'h9ABC, 1'b0, 1, 2, 16'h9ABC ^ (16'h1 << i), 1'b0, 1, "R12 bit flip");

        // R13 stray echo with nothing pending
        do_reset();
        rx_valid = 1; rx_data = 16'h1111; rx_is_cmd = 0;
        @(negedge clk);
        rx_valid = 0;
        repeat (WIN + 3) @(negedge clk);
        chk(loop_fail == 1'b0, "R13 stray echo ignored", loop_fail, 0);

        // R14 fail stays set across a later good word
        loop_case(16'h5555, 1'b0, 0, 0, 16'h0, 1'b0, 1, "R14 setup fail");
        load_word(16'h3333, 1'b1);
        @(negedge clk);
        while (!tx_active) @(negedge clk);
        wait_idle();
        rx_valid = 1; rx_data = 16'h3333; rx_is_cmd = 1;
        @(negedge clk);
        rx_valid = 0;
        repeat (WIN + 3) @(negedge clk);
        chk(loop_fail == 1'b1, "R14 sticky", loop_fail, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule